// File: doc/BRIEF.md
# Interrupt Source Delivery Controller

This block holds one delivery state machine for each of a set of interrupt sources. It sits between the raw interrupt lines coming from devices and a presentation controller that hands interrupts to a processor. Each source is configured as edge-triggered or level-triggered. In edge mode it latches rising edges. In level mode it follows the line. When a source has work and is allowed to deliver, it raises a request that carries the priority programmed for it and a fixed source identifier.

The presenter answers a request with accept or reject. Accept masks the source implicitly: it stays quiet until the presenter sends the end-of-interrupt (EOI) for it, and the EOI lifts that implicit mask. Reject means no processor could take the interrupt. The source then keeps it pending, waits a programmable number of cycles and requests again. An explicit per-source mask, or the all-ones priority value, holds delivery back without discarding anything. Unmasking resumes delivery. Edges that arrive while an interrupt is in service are latched so that they are not lost, because nothing downstream replays an edge event.

Each source has its own request, accept, reject and EOI signals, so sources never block one another. Configuration is written one source at a time through a select-and-write port.

Top module: `irq_source_bank`

## Requirements
- R1: After reset every source is masked with priority 0xFF (disabled) and no request output is high.
- R2: Accept given while a source is requesting drops its request on the next cycle. The source does not request again until its EOI, whatever its line does in the meantime.
- R3: Reject given while a source is requesting drops the request. If the source is still eligible, it requests again exactly `retry_cycles_i`+1 cycles after the reject edge.
- R4: In edge mode (config edge bit = 1), a rising edge on the line latched at one clock edge produces a request after the following clock edge. An edge that arrives while the source awaits EOI is held, and it produces a new request one cycle after the EOI has been taken.
- R5: In edge mode, one rising edge gives exactly one delivery. After the EOI, a line that stays high produces no further request.
- R6: In level mode (config edge bit = 0), the request follows a high line one cycle later. After an EOI it is raised again if the line is still high. A line that falls while the source is requesting withdraws the request on the next cycle.
- R7: While the config mask bit is 1, no new request is raised, and an edge that arrives while masked is kept. One cycle after the unmask takes effect, the source requests.
- R8: A programmed priority of 0xFF holds delivery back exactly as the mask does. Writing another value releases it.
- R9: EOI given to a source that is not awaiting EOI, and accept or reject given to a source that is not requesting, have no effect on its state or on its request output.
- R10: While a source requests, its priority field shows the last programmed priority and its identifier field shows ID_BASE plus the source index.
- R11: Handshake signals given to one source do not change the request of another source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_line_i | input | NUM_SRC | Raw interrupt line per source |
| cfg_we_i | input | 1 | Writes configuration of the selected source |
| cfg_sel_i | input | SEL_W | Index of the source to configure |
| cfg_prio_i | input | 8 | Priority to program (0xFF disables) |
| cfg_edge_i | input | 1 | 1 = edge mode, 0 = level mode |
| cfg_mask_i | input | 1 | 1 = explicit mask set |
| retry_cycles_i | input | CNT_W | Wait after a reject before requesting again |
| req_o | output | NUM_SRC | Request per source |
| req_prio_o | output | NUM_SRC*8 | Priority per source, packed by index |
| req_id_o | output | NUM_SRC*ID_W | Source identifier per source, packed by index |
| accept_i | input | NUM_SRC | Presenter accepted the request |
| reject_i | input | NUM_SRC | Presenter rejected the request |
| eoi_i | input | NUM_SRC | End of interrupt per source |

## Verification
The bench builds the bank with two sources, ID_BASE 4 and a 4-bit retry counter. Two sources are enough to check that one source does not disturb the other. The small counter lets the bench sweep every retry wait from 0 to 3 and measure the exact cycle of the re-request. Because the configuration space is small, the bench can also sweep every combination of mode, mask and disabled priority, and compare the request against one computed in the bench.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

    localparam int unsigned PRIO_W = 8;
    localparam logic [PRIO_W-1:0] PRIO_OFF = '1;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_REQ      = 2'd1,
        S_SERVICE  = 2'd2,
        S_BACKOFF  = 2'd3
    } src_state_e;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              edge_mode;
        logic              mask;
    } src_cfg_t;

    localparam src_cfg_t CFG_RESET = '{prio: PRIO_OFF, edge_mode: 1'b0, mask: 1'b1};

    function automatic logic deliverable(input src_cfg_t c, input logic pend);
        return pend && !c.mask && (c.prio != PRIO_OFF);
    endfunction

endpackage

// File: rtl/irq_detect.sv
module irq_detect (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    input  logic edge_mode_i,
    input  logic take_i,
    output logic pend_o
);
    logic line_q;
    logic edge_hold;
    logic rise;

    assign rise = line_i && !line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q    <= 1'b0;
            edge_hold <= 1'b0;
        end else begin
            line_q <= line_i;
            if (!edge_mode_i)
                edge_hold <= 1'b0;
            else if (rise)
                edge_hold <= 1'b1;
            else if (take_i)
                edge_hold <= 1'b0;
        end
    end

    assign pend_o = edge_mode_i ? edge_hold : line_i;

    // R4: a new edge in edge mode is never dropped
    a_r4_edge_latched: assert property (@(posedge clk) disable iff (rst)
        (edge_mode_i && rise) |=> (edge_hold || !edge_mode_i));

endmodule

// File: rtl/irq_retry_timer.sv
module irq_retry_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (run_i && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = run_i && (cnt_q == '0);

    // R3: the wait only counts down while running
    a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
        (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/irq_src_fsm.sv
module irq_src_fsm
    import irq_src_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eligible_i,
    input  logic             accept_i,
    input  logic             reject_i,
    input  logic             eoi_i,
    input  logic [CNT_W-1:0] retry_cycles_i,
    output logic             req_o,
    output logic             take_o
);
    src_state_e state_q, state_d;
    logic       in_backoff;
    logic       wait_done;
    logic       start_wait;

    assign in_backoff = (state_q == S_BACKOFF);
    assign start_wait = (state_q == S_REQ) && !accept_i && reject_i;
    assign take_o     = (state_q == S_REQ) && accept_i;

    irq_retry_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (start_wait),
        .load_val_i (retry_cycles_i),
        .run_i      (in_backoff),
        .done_o     (wait_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (eligible_i) state_d = S_REQ;
            S_REQ: begin
                if (accept_i)         state_d = S_SERVICE;
                else if (reject_i)    state_d = S_BACKOFF;
                else if (!eligible_i) state_d = S_IDLE;
            end
            S_SERVICE: if (eoi_i) state_d = S_IDLE;
            S_BACKOFF: if (wait_done) state_d = eligible_i ? S_REQ : S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    assign req_o = (state_q == S_REQ);

    // R2: accepted request disappears and stays away until EOI
    a_r2_accept_drops: assert property (@(posedge clk) disable iff (rst)
        (req_o && accept_i) |=> !req_o);
    a_r2_hold_until_eoi: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_SERVICE && !eoi_i) |=> !req_o);
    // R3: rejected request is withdrawn for the wait
    a_r3_reject_drops: assert property (@(posedge clk) disable iff (rst)
        (req_o && reject_i && !accept_i) |=> !req_o);
    // R7, R8: an ineligible idle source raises nothing
    a_r7_no_new_req: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE && !eligible_i) |=> !req_o);
    // R9: stray EOI on an idle source is ignored
    a_r9_stray_eoi: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE && eoi_i && !eligible_i) |=> (state_q == S_IDLE));

endmodule

// File: rtl/irq_source_bank.sv
module irq_source_bank
    import irq_src_pkg::*;
#(
    parameter int unsigned NUM_SRC = 4,
    parameter int unsigned ID_W    = 6,
    parameter int unsigned ID_BASE = 16,
    parameter int unsigned CNT_W   = 8,
    localparam int unsigned SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_SRC-1:0]        irq_line_i,
    input  logic                      cfg_we_i,
    input  logic [SEL_W-1:0]          cfg_sel_i,
    input  logic [PRIO_W-1:0]         cfg_prio_i,
    input  logic                      cfg_edge_i,
    input  logic                      cfg_mask_i,
    input  logic [CNT_W-1:0]          retry_cycles_i,
    output logic [NUM_SRC-1:0]        req_o,
    output logic [NUM_SRC*PRIO_W-1:0] req_prio_o,
    output logic [NUM_SRC*ID_W-1:0]   req_id_o,
    input  logic [NUM_SRC-1:0]        accept_i,
    input  logic [NUM_SRC-1:0]        reject_i,
    input  logic [NUM_SRC-1:0]        eoi_i
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int unsigned SRC_ID = ID_BASE + i;
        src_cfg_t cfg_q;
        logic     pend;
        logic     take;
        logic     elig;

        always_ff @(posedge clk) begin
            if (rst)
                cfg_q <= CFG_RESET;
            else if (cfg_we_i && cfg_sel_i == SEL_W'(i))
                cfg_q <= '{prio: cfg_prio_i, edge_mode: cfg_edge_i, mask: cfg_mask_i};
        end

        irq_detect u_detect (
            .clk         (clk),
            .rst         (rst),
            .line_i      (irq_line_i[i]),
            .edge_mode_i (cfg_q.edge_mode),
            .take_i      (take),
            .pend_o      (pend)
        );

        assign elig = deliverable(cfg_q, pend);

        irq_src_fsm #(.CNT_W(CNT_W)) u_fsm (
            .clk            (clk),
            .rst            (rst),
            .eligible_i     (elig),
            .accept_i       (accept_i[i]),
            .reject_i       (reject_i[i]),
            .eoi_i          (eoi_i[i]),
            .retry_cycles_i (retry_cycles_i),
            .req_o          (req_o[i]),
            .take_o         (take)
        );

        assign req_prio_o[i*PRIO_W +: PRIO_W] = cfg_q.prio;
        assign req_id_o[i*ID_W +: ID_W]       = ID_W'(SRC_ID);

        // R1: nothing requests in the cycle after reset
        a_r1_reset_quiet: assert property (@(posedge clk)
            rst |=> !req_o[i]);
    end

endmodule

// File: tb/tb_irq_source_bank.sv
module tb_irq_source_bank;
    localparam int unsigned N     = 2;
    localparam int unsigned ID_W  = 4;
    localparam int unsigned IDB   = 4;
    localparam int unsigned CNT_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] line = '0, acc = '0, rej = '0, eoi = '0;
    logic cfg_we = 1'b0, cfg_edge = 1'b0, cfg_mask = 1'b1;
    logic [0:0] cfg_sel = '0;
    logic [7:0] cfg_prio = 8'hFF;
    logic [CNT_W-1:0] retry = '0;
    logic [N-1:0] req;
    logic [N*8-1:0] prio_o;
    logic [N*ID_W-1:0] id_o;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_source_bank #(.NUM_SRC(N), .ID_W(ID_W), .ID_BASE(IDB), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .irq_line_i(line), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
        .cfg_prio_i(cfg_prio), .cfg_edge_i(cfg_edge), .cfg_mask_i(cfg_mask),
        .retry_cycles_i(retry), .req_o(req), .req_prio_o(prio_o), .req_id_o(id_o),
        .accept_i(acc), .reject_i(rej), .eoi_i(eoi));

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cfg(input int s, input int p, input bit e, input bit m);
        cfg_we = 1; cfg_sel = 1'(s); cfg_prio = 8'(p); cfg_edge = e; cfg_mask = m;
        step(1);
        cfg_we = 0;
    endtask

    task automatic pulse_acc(input int s); acc[s] = 1; step(1); acc[s] = 0; endtask
    task automatic pulse_rej(input int s); rej[s] = 1; step(1); rej[s] = 0; endtask
    task automatic pulse_eoi(input int s); eoi[s] = 1; step(1); eoi[s] = 0; endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 0;
        step(1);
        chk("R1 reset req", int'(req), 0);
        chk("R1 reset prio src0", int'(prio_o[7:0]), 255);
        line = 2'b11; step(3);
        chk("R1 masked after reset", int'(req), 0);
        line = 0; step(2);

        // edge mode on source 0
        cfg(0, 5, 1, 0);
        line[0] = 1; step(1);
        chk("R4 latched not yet requesting", int'(req[0]), 0);
        step(1);
        chk("R4 edge request", int'(req[0]), 1);
        chk("R10 prio", int'(prio_o[7:0]), 5);
        chk("R10 id src0", int'(id_o[ID_W-1:0]), IDB);
        pulse_acc(0);
        chk("R2 accept drops", int'(req[0]), 0);
        line[0] = 0; step(1); line[0] = 1; step(3);
        chk("R2 quiet until EOI", int'(req[0]), 0);
        pulse_eoi(0);
        chk("R4 eoi taken", int'(req[0]), 0);
        step(1);
        chk("R4 held edge delivered", int'(req[0]), 1);
        pulse_acc(0); pulse_eoi(0); step(5);
        chk("R5 single delivery", int'(req[0]), 0);

        // retry sweep
        line[0] = 0; step(1); line[0] = 1; step(2);
        for (int d = 0; d < 4; d++) begin
            retry = CNT_W'(d);
            chk("R3 requesting before reject", int'(req[0]), 1);
            pulse_rej(0);
            chk("R3 dropped after reject", int'(req[0]), 0);
            step(d);
            chk("R3 still waiting", int'(req[0]), 0);
            step(1);
            chk("R3 retried on time", int'(req[0]), 1);
        end
        pulse_eoi(0);
        chk("R9 eoi while requesting ignored", int'(req[0]), 1);
        pulse_acc(0); pulse_eoi(0); line[0] = 0; step(2);

        // level mode on source 1
        cfg(1, 9, 0, 0);
        line[1] = 1; step(1);
        chk("R6 level request", int'(req[1]), 1);
        chk("R10 id src1", int'(id_o[2*ID_W-1:ID_W]), IDB + 1);
        pulse_acc(1);
        chk("R2 level accept drops", int'(req[1]), 0);
        step(3);
        chk("R2 level quiet until EOI", int'(req[1]), 0);
        pulse_eoi(1); step(1);
        chk("R6 re-request after EOI", int'(req[1]), 1);
        line[1] = 0; step(1);
        chk("R6 withdraw on fall", int'(req[1]), 0);

        // stray handshakes on idle source 1
        eoi[1] = 1; acc[1] = 1; rej[1] = 1; step(1);
        eoi[1] = 0; acc[1] = 0; rej[1] = 0;
        chk("R9 stray handshake", int'(req[1]), 0);
        line[1] = 1; step(1);
        chk("R9 state untouched", int'(req[1]), 1);

        // independence
        line[0] = 1; step(2);
        chk("R11 both requesting", int'(req), 3);
        pulse_acc(0);
        chk("R11 other source kept", int'(req), 2);
        pulse_eoi(0); line = 0; step(2);

        // mask defers an edge
        cfg(0, 5, 1, 1);
        line[0] = 1; step(4);
        chk("R7 masked no request", int'(req[0]), 0);
        cfg(0, 5, 1, 0);
        chk("R7 unmask edge", int'(req[0]), 0);
        step(1);
        chk("R7 delivery resumes", int'(req[0]), 1);
        pulse_acc(0); pulse_eoi(0); line[0] = 0; step(2);

        // priority 0xFF disables
        cfg(1, 255, 0, 0);
        line[1] = 1; step(3);
        chk("R8 prio FF holds", int'(req[1]), 0);
        cfg(1, 3, 0, 0); step(1);
        chk("R8 released", int'(req[1]), 1);
        chk("R10 new prio", int'(prio_o[15:8]), 3);
        line[1] = 0; step(2);

        // sweep mode x mask x disable on source 1
        for (int e = 0; e < 2; e++)
            for (int m = 0; m < 2; m++)
                for (int z = 0; z < 2; z++) begin
                    cfg(1, z ? 255 : 7, 1'(e), 1'(m));
                    line[1] = 1; step(3);
                    chk("R7 R8 sweep", int'(req[1]), (m == 0 && z == 0) ? 1 : 0);
                    line[1] = 0;
                    cfg(1, 7, 0, 1); step(2);
                    chk("R6 sweep cleanup", int'(req[1]), 0);
                end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule